// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Background Refresh

This block connects a synchronous single-bit request port to an asynchronous 64K x 1 dynamic memory that has one shared row/column address bus. Each request carries a 16-bit word address, a read/write flag and one data bit. The controller splits the address into a row half and a column half. It strobes the row first and the column second. It then keeps the row open, so that later requests to the same row need only a new column strobe.

Because reading a row destroys its stored charge, the controller always spends a restore interval with the row strobe still low before it closes a row. It then holds the row strobe high for a precharge interval. A free-running timer asks for a refresh often enough to cover all rows within the retention window. A pending refresh closes any open row and is served before the next user request. Each refresh is a row-strobe-only cycle on the next row of an ascending counter.

All timing is given as parameters counted in clock cycles. The defaults suit a 50 MHz clock: row activation 3, column strobe 1, page column spacing 2, restore 2, precharge 2, and a refresh interval of 195 cycles.

Top module: `dramc_page_ctrl`

## Requirements
- R1: The row half of the address (bits 15:8) is on `dram_addr` when `dram_ras_n` falls. The column half (bits 7:0) is on `dram_addr` when `dram_cas_n` falls.
- R2: `dram_cas_n` is low only while `dram_ras_n` is low. `dram_addr` does not change while `dram_cas_n` stays low.
- R3: `dram_ras_n` has been low for at least ACT_CYC cycles when `dram_cas_n` falls. Each column strobe stays low for exactly CAS_CYC cycles.
- R4: Before `dram_ras_n` rises, it stays low with `dram_cas_n` high for at least RESTORE_CYC cycles. After it rises, `dram_ras_n` stays high for at least PRE_CYC cycles before it falls again.
- R5: A request to the row that is already open produces only a column strobe. A read of this kind has a latency of CAS_CYC cycles. Column strobe falling edges within one open row are at least PAGE_CYC cycles apart.
- R6: A read with no row open has a latency of ACT_CYC+CAS_CYC cycles. A read to a different row than the open one has a latency of RESTORE_CYC+PRE_CYC+ACT_CYC+CAS_CYC cycles. Latency is counted from the accepting clock edge to the first cycle in which `rd_valid` is high. `rd_valid` is a one-cycle pulse, and `rd_data` carries the addressed bit.
- R7: For a write, `dram_we_n` is low during the column strobe and `dram_din` equals the request data bit. A write produces no `rd_valid` pulse.
- R8: A refresh is a row-strobe cycle with no column strobe. Refreshes are spaced about REF_INTERVAL cycles apart, and their rows go 0, 1, 2 ... 255 and then wrap to 0.
- R9: A pending refresh closes an open row and is served before further user requests. The next access after a refresh therefore sees no open row.
- R10: After reset, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, `rd_valid` is low and `req_ready` is high. `req_ready` is low while a row is being closed or opened and while a refresh is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The controller accepts the request at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address: row in bits 15:8, column in bits 7:0 |
| req_wdata | input | 1 | Data bit to write |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds a read result |
| rd_data | output | 1 | Bit returned by a read |
| dram_addr | output | 8 | Shared row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_din | output | 1 | Data bit to the memory |
| dram_dout | input | 1 | Data bit from the memory |

## Verification
The bench attacks three latency classes: an open-row hit, no open row, and a row change. A controller that skipped the restore or the precharge on a row change would return data too early. One that reopened an already open row would return it too late. A long run of hits on one row checks that a refresh still closes the page. A controller that starved refresh would show no row-strobe-only cycles. One that forgot the page was closed would return a hit latency with no row strobe in front of it. A monitor checks every strobe edge for row/column order, minimum spacing and restore time. It also follows the refresh row sequence through its wrap past 255, where an off-by-one counter or a skipped row shows up at once.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ACT     = 3'd1,
        ST_CAS     = 3'd2,
        ST_GAP     = 3'd3,
        ST_OPEN    = 3'd4,
        ST_RESTORE = 3'd5,
        ST_PRE     = 3'd6
    } dramc_state_e;

endpackage

// File: rtl/dramc_addr_split.sv
// Splits a flat word address into its row and column indices (R1).
module dramc_addr_split #(
    parameter int ROW_W = 8,
    parameter int COL_W = 8
) (
    input  logic [ROW_W+COL_W-1:0] addr,
    output logic [ROW_W-1:0]       row,
    output logic [COL_W-1:0]       col
);
    assign row = addr[ROW_W+COL_W-1:COL_W];
    assign col = addr[COL_W-1:0];
endmodule

// File: rtl/dramc_refresh_timer.sv
// Free-running interval timer with a sticky refresh request (R8).
module dramc_refresh_timer #(
    parameter int INTERVAL = 195
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);
    localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          pend;
    } tmr_s;

    tmr_s q, d;
    logic tick;

    always_comb begin
        d    = q;
        tick = (q.cnt == '0);
        if (tick) begin
            d.cnt = TW'(INTERVAL - 1);
        end else begin
            d.cnt = q.cnt - 1'b1;
        end
        d.pend = (q.pend & ~ack) | tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt  <= TW'(INTERVAL - 1);
            q.pend <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign pending = q.pend;
endmodule

// File: rtl/dramc_strobe_drv.sv
// Decodes the sequencer state into the memory pins (R1, R2, R7).
module dramc_strobe_drv
    import dramc_pkg::*;
#(
    parameter int ROW_W = 8,
    parameter int COL_W = 8
) (
    input  dramc_state_e     state,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic             wr,
    input  logic             wd,
    output logic [ROW_W-1:0] addr,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic             din
);
    logic [ROW_W-1:0] col_ext;

    generate
        if (COL_W == ROW_W) begin : g_col_same
            assign col_ext = col;
        end else begin : g_col_pad
            assign col_ext = {{(ROW_W - COL_W){1'b0}}, col};
        end
    endgenerate

    always_comb begin
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        din   = 1'b0;
        addr  = row;
        case (state)
            ST_ACT, ST_GAP, ST_OPEN, ST_RESTORE: begin
                ras_n = 1'b0;
            end
            ST_CAS: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = ~wr;
                din   = wd;
                addr  = col_ext;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dramc_page_ctrl.sv
// Page-mode controller: row-then-column strobing, open-row reuse,
// restore before close, and background row refresh.
module dramc_page_ctrl
    import dramc_pkg::*;
#(
    parameter int ROW_W        = 8,
    parameter int COL_W        = 8,
    parameter int ACT_CYC      = 3,
    parameter int CAS_CYC      = 1,
    parameter int PAGE_CYC     = 2,
    parameter int RESTORE_CYC  = 2,
    parameter int PRE_CYC      = 2,
    parameter int REF_INTERVAL = 195
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic                   req_wdata,
    output logic                   rd_valid,
    output logic                   rd_data,
    output logic [ROW_W-1:0]       dram_addr,
    output logic                   dram_ras_n,
    output logic                   dram_cas_n,
    output logic                   dram_we_n,
    output logic                   dram_din,
    input  logic                   dram_dout
);
    localparam int GAP_CYC = PAGE_CYC - CAS_CYC;
    localparam int CNT_W   = $clog2(ACT_CYC + CAS_CYC + PAGE_CYC + RESTORE_CYC + PRE_CYC + 1);
    localparam logic [CNT_W-1:0] ACT_LD = CNT_W'(ACT_CYC - 1);
    localparam logic [CNT_W-1:0] CAS_LD = CNT_W'(CAS_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LD = CNT_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] RST_LD = CNT_W'(RESTORE_CYC - 1);
    localparam logic [CNT_W-1:0] PRE_LD = CNT_W'(PRE_CYC - 1);

    typedef struct packed {
        dramc_state_e     state;
        logic [CNT_W-1:0] cnt;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             wr;
        logic             wd;
        logic             ref_act;
        logic             miss_pend;
        logic [ROW_W-1:0] ref_row;
        logic             rd_valid;
        logic             rd_data;
    } ctrl_s;

    ctrl_s q, d;

    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic             ref_pend;
    logic             ref_ack;
    logic             cnt_done;

    dramc_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
        .addr (req_addr),
        .row  (req_row),
        .col  (req_col)
    );

    dramc_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ref_ack),
        .pending (ref_pend)
    );

    dramc_strobe_drv #(.ROW_W(ROW_W), .COL_W(COL_W)) u_drv (
        .state (q.state),
        .row   (q.row),
        .col   (q.col),
        .wr    (q.wr),
        .wd    (q.wd),
        .addr  (dram_addr),
        .ras_n (dram_ras_n),
        .cas_n (dram_cas_n),
        .we_n  (dram_we_n),
        .din   (dram_din)
    );

    assign cnt_done = (q.cnt == '0);

    always_comb begin
        d          = q;
        d.rd_valid = 1'b0;
        ref_ack    = 1'b0;
        req_ready  = 1'b0;
        case (q.state)
            ST_IDLE: begin
                req_ready = ~ref_pend;                 // R9, R10
                if (ref_pend) begin
                    ref_ack   = 1'b1;
                    d.state   = ST_ACT;
                    d.cnt     = ACT_LD;
                    d.ref_act = 1'b1;
                    d.row     = q.ref_row;             // R8 ascending rows
                    d.ref_row = q.ref_row + 1'b1;
                end else if (req_valid) begin
                    d.state   = ST_ACT;
                    d.cnt     = ACT_LD;
                    d.ref_act = 1'b0;
                    d.row     = req_row;
                    d.col     = req_col;
                    d.wr      = req_write;
                    d.wd      = req_wdata;
                end
            end
            ST_ACT: begin                              // R3 activation time
                if (cnt_done) begin
                    if (q.ref_act) begin
                        d.state = ST_RESTORE;
                        d.cnt   = RST_LD;
                    end else begin
                        d.state = ST_CAS;
                        d.cnt   = CAS_LD;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_CAS: begin
                if (cnt_done) begin
                    if (!q.wr) begin                   // R6 read return
                        d.rd_valid = 1'b1;
                        d.rd_data  = dram_dout;
                    end
                    if (GAP_CYC > 0) begin             // R5 page spacing
                        d.state = ST_GAP;
                        d.cnt   = GAP_LD;
                    end else begin
                        d.state = ST_OPEN;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_GAP: begin
                if (cnt_done) begin
                    d.state = ST_OPEN;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_OPEN: begin
                req_ready = ~ref_pend;
                if (ref_pend) begin                    // R9 close for refresh
                    d.state     = ST_RESTORE;
                    d.cnt       = RST_LD;
                    d.miss_pend = 1'b0;
                end else if (req_valid) begin
                    d.col = req_col;
                    d.wr  = req_write;
                    d.wd  = req_wdata;
                    if (req_row == q.row) begin        // R5 page hit
                        d.state = ST_CAS;
                        d.cnt   = CAS_LD;
                    end else begin                     // R6 row change
                        d.row       = req_row;
                        d.miss_pend = 1'b1;
                        d.state     = ST_RESTORE;
                        d.cnt       = RST_LD;
                    end
                end
            end
            ST_RESTORE: begin                          // R4 write-back
                if (cnt_done) begin
                    d.state = ST_PRE;
                    d.cnt   = PRE_LD;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_PRE: begin                              // R4 precharge
                if (cnt_done) begin
                    d.ref_act = 1'b0;
                    if (q.miss_pend) begin
                        d.miss_pend = 1'b0;
                        d.state     = ST_ACT;
                        d.cnt       = ACT_LD;
                    end else begin
                        d.state = ST_IDLE;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_valid = q.rd_valid;
    assign rd_data  = q.rd_data;
endmodule

// File: rtl/dramc_page_ctrl_chk.sv
// Protocol checker bound to the controller.
module dramc_page_ctrl_chk #(
    parameter int ACT_CYC     = 3,
    parameter int RESTORE_CYC = 2,
    parameter int PRE_CYC     = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] dram_addr,
    input logic       dram_ras_n,
    input logic       dram_cas_n,
    input logic       dram_we_n,
    input logic       rd_valid,
    input logic       req_ready
);
    localparam int CW = $clog2(ACT_CYC + RESTORE_CYC + PRE_CYC + 2) + 1;
    localparam logic [CW-1:0] SAT = '1;

    logic [CW-1:0] ras_low_cnt;
    logic [CW-1:0] ras_high_cnt;
    logic [CW-1:0] cas_idle_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_low_cnt  <= '0;
            ras_high_cnt <= CW'(PRE_CYC);
            cas_idle_cnt <= '0;
        end else begin
            if (!dram_ras_n) begin
                ras_low_cnt  <= (ras_low_cnt == SAT) ? SAT : ras_low_cnt + 1'b1;
                ras_high_cnt <= '0;
            end else begin
                ras_low_cnt  <= '0;
                ras_high_cnt <= (ras_high_cnt == SAT) ? SAT : ras_high_cnt + 1'b1;
            end
            if (dram_ras_n || !dram_cas_n) begin
                cas_idle_cnt <= '0;
            end else begin
                cas_idle_cnt <= (cas_idle_cnt == SAT) ? SAT : cas_idle_cnt + 1'b1;
            end
        end
    end

    a_r2_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr));

    a_r3_act_before_cas: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> (ras_low_cnt >= CW'(ACT_CYC)));

    a_r4_restore_before_close: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> (cas_idle_cnt >= CW'(RESTORE_CYC)));

    a_r4_precharge_time: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (ras_high_cnt >= CW'(PRE_CYC)));

    a_r6_rd_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r7_write_no_return: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && !dram_we_n) |=> !rd_valid);

    a_r10_busy_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> !req_ready);
endmodule

bind dramc_page_ctrl dramc_page_ctrl_chk #(
    .ACT_CYC     (ACT_CYC),
    .RESTORE_CYC (RESTORE_CYC),
    .PRE_CYC     (PRE_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dram_addr  (dram_addr),
    .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n),
    .dram_we_n  (dram_we_n),
    .rd_valid   (rd_valid),
    .req_ready  (req_ready)
);

// File: tb/dramc_page_ctrl_tb_top.sv
module dramc_page_ctrl_tb_top;
    localparam int ACT_CYC      = 3;
    localparam int CAS_CYC      = 1;
    localparam int PAGE_CYC     = 2;
    localparam int RESTORE_CYC  = 2;
    localparam int PRE_CYC      = 2;
    localparam int REF_INTERVAL = 195;

    // {write, data, addr}
    localparam logic [17:0] VECS [8] = '{
        18'h31234, 18'h01234, 18'h212FF, 18'h012FF,
        18'h05600, 18'h35601, 18'h01234, 18'h05601
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_wdata = 1'b0;
    logic        rd_valid;
    logic        rd_data;
    logic [7:0]  dram_addr;
    logic        dram_ras_n;
    logic        dram_cas_n;
    logic        dram_we_n;
    logic        dram_din;
    logic        dram_dout = 1'b0;

    always #10 clk = ~clk;

    dramc_page_ctrl #(
        .ACT_CYC(ACT_CYC), .CAS_CYC(CAS_CYC), .PAGE_CYC(PAGE_CYC),
        .RESTORE_CYC(RESTORE_CYC), .PRE_CYC(PRE_CYC), .REF_INTERVAL(REF_INTERVAL)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_din(dram_din), .dram_dout(dram_dout)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit cell_init(input int a);
        return ^(a * 37 + 5);
    endfunction

    bit mem [int];
    bit shadow [int];

    function automatic bit mem_rd(input int a);
        return mem.exists(a) ? mem[a] : cell_init(a);
    endfunction

    function automatic bit shadow_rd(input int a);
        return shadow.exists(a) ? shadow[a] : cell_init(a);
    endfunction

    // ---------------- memory model and strobe monitor ----------------
    int   cyc = 0;
    always @(posedge clk) cyc++;

    logic [15:0] cur_addr = '0;
    bit          cur_wdata = 1'b0;
    bit   prev_ras = 1'b1, prev_cas = 1'b1;
    int   m_row = 0, m_col = 0;
    int   ras_low_cnt = 0, ras_high_cnt = 100, cas_low_cnt = 0;
    int   cas_idle_cnt = 0, since_cas = 0;
    bit   cas_seen = 1'b0;
    int   ras_fall_cyc = 0, last_ref_fall = 0;
    int   n_ref = 0, exp_ref_row = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ras && !dram_ras_n) begin
                chk(ras_high_cnt >= PRE_CYC, "R4 precharge", ras_high_cnt, PRE_CYC);
                m_row        = int'(dram_addr);
                cas_seen     = 1'b0;
                ras_fall_cyc = cyc;
            end
            if (prev_cas && !dram_cas_n) begin
                chk(!dram_ras_n, "R2 cas inside ras", int'(dram_ras_n), 0);
                chk(ras_low_cnt >= ACT_CYC, "R3 activation", ras_low_cnt, ACT_CYC);
                if (cas_seen)
                    chk(since_cas >= PAGE_CYC, "R5 page spacing", since_cas, PAGE_CYC);
                m_col = int'(dram_addr);
                chk(((m_row << 8) | m_col) == int'(cur_addr), "R1 row/col split",
                    (m_row << 8) | m_col, int'(cur_addr));
                if (!dram_we_n) begin
                    chk(dram_din == cur_wdata, "R7 write data", int'(dram_din), int'(cur_wdata));
                    mem[(m_row << 8) | m_col] = dram_din;
                end
                dram_dout = mem_rd((m_row << 8) | m_col);
                cas_seen  = 1'b1;
                since_cas = 0;
            end
            if (!prev_cas && dram_cas_n)
                chk(cas_low_cnt == CAS_CYC, "R3 cas width", cas_low_cnt, CAS_CYC);
            if (!prev_ras && dram_ras_n) begin
                chk(!req_ready, "R10 busy while closing", int'(req_ready), 0);
                chk(cas_idle_cnt >= RESTORE_CYC, "R4 restore", cas_idle_cnt, RESTORE_CYC);
                if (!cas_seen) begin
                    chk(m_row == exp_ref_row, "R8 refresh row", m_row, exp_ref_row);
                    if (n_ref > 0)
                        chk((ras_fall_cyc - last_ref_fall) >= REF_INTERVAL - 24 &&
                            (ras_fall_cyc - last_ref_fall) <= REF_INTERVAL + 24,
                            "R8 refresh spacing", ras_fall_cyc - last_ref_fall, REF_INTERVAL);
                    last_ref_fall = ras_fall_cyc;
                    exp_ref_row   = (exp_ref_row + 1) % 256;
                    n_ref++;
                end
            end
            ras_low_cnt  = !dram_ras_n ? ras_low_cnt + 1 : 0;
            ras_high_cnt =  dram_ras_n ? ras_high_cnt + 1 : 0;
            cas_low_cnt  = !dram_cas_n ? cas_low_cnt + 1 : 0;
            cas_idle_cnt = (dram_ras_n || !dram_cas_n) ? 0 : cas_idle_cnt + 1;
            since_cas++;
        end
        prev_ras = dram_ras_n;
        prev_cas = dram_cas_n;
    end

    // ---------------- request driver ----------------
    int open_row = -1;
    int last_nref = 0;

    task automatic run_op(input bit wr, input logic [15:0] a, input bit wd);
        int lat;
        int nref_at;
        int row;
        int exp_lat;
        string tag;
        bit stray;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        cur_addr  = a;
        cur_wdata = wd;
        nref_at   = n_ref;
        @(negedge clk);
        req_valid = 1'b0;
        row = int'(a[15:8]);
        tag = "R6 row change";
        if (nref_at != last_nref) begin
            open_row = -1;
            tag = "R9 page closed by refresh";
        end
        if (open_row == row) begin
            exp_lat = CAS_CYC;
            tag = "R5 page hit";
        end else if (open_row < 0) begin
            exp_lat = ACT_CYC + CAS_CYC;
            if (nref_at == last_nref) tag = "R6 no open row";
        end else begin
            exp_lat = RESTORE_CYC + PRE_CYC + ACT_CYC + CAS_CYC;
        end
        if (!wr) begin
            lat = 0;
            while (!rd_valid && lat < 40) begin
                @(negedge clk);
                lat++;
            end
            chk(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
            chk(rd_data == shadow_rd(int'(a)), "R6 read data", int'(rd_data),
                int'(shadow_rd(int'(a))));
            @(negedge clk);
            chk(!rd_valid, "R6 single pulse", int'(rd_valid), 0);
        end else begin
            shadow[int'(a)] = wd;
            stray = 1'b0;
            for (int k = 0; k < ACT_CYC + CAS_CYC + 2; k++) begin
                @(negedge clk);
                if (rd_valid) stray = 1'b1;
            end
            chk(!stray, "R7 no read pulse on write", int'(stray), 0);
        end
        open_row  = row;
        last_nref = nref_at;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n, "R10 reset strobes",
            int'({dram_ras_n, dram_cas_n, dram_we_n}), 7);
        chk(!rd_valid, "R10 reset rd_valid", int'(rd_valid), 0);
        chk(req_ready, "R10 reset ready", int'(req_ready), 1);

        // sync to the end of a refresh so the table fits in one interval
        begin
            int s = n_ref;
            while (n_ref == s) @(negedge clk);
        end
        open_row  = -1;
        last_nref = n_ref;
        for (int i = 0; i < 8; i++) begin
            run_op(VECS[i][17], VECS[i][15:0], VECS[i][16]);
        end

        // long run of hits on one row across several refreshes (R9)
        begin
            int s = n_ref;
            for (int i = 0; i < 250; i++) begin
                run_op(i % 5 == 0, 16'h7A00 | 16'(i % 256), i[1]);
            end
            chk(n_ref - s >= 2, "R9 refresh not starved", n_ref - s, 2);
        end

        // idle until the refresh row counter has wrapped (R8)
        while (n_ref < 260) @(negedge clk);
        chk(n_ref >= 260, "R8 wrap reached", n_ref, 260);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule